// File: doc/BRIEF.md
# Configuration Space Register File with Region Decode

This block holds the 256-byte configuration space of one device function. Software reaches it through a single access port carrying a byte offset, a length of 1, 2 or 4 bytes, a write flag and 32 bits of data. Bytes are little-endian: the byte at the lowest offset is the least significant byte of the data word. Reads are combinational. Writes commit on the rising clock edge.

Inside the space sit six base-address registers and one expansion-ROM base register. Their sizes and I/O-or-memory types are fixed by parameters. From these registers and from the two enable bits of the command register, the block keeps seven live decode windows, each with a base and an enable. It also answers, combinationally, which windows contain a queried address in a chosen address space.

The size parameters have these limits:
- Each size is zero or a power of two.
- An I/O region is at least 4 bytes.
- A memory region is at least 16 bytes.
- The ROM region is at least 2 bytes.

Top module: `cfg_space`

## Requirements
- R1: The read length code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. A 4-byte read is served as 4 bytes only at offset 0xfc or below. Otherwise it is served as 2 bytes at offset 0xfe or below, and otherwise as 1 byte. A 2-byte read at 0xff is served as 1 byte.
- R2: Data is little-endian, with byte offset+k on bits 8k+7..8k. Bytes beyond the served width read as zero.
- R3: Writes are applied one byte at a time, using the same length code as reads. A write that would run past offset 0xff stops after 0xff, with no wrap to offset 0x00.
- R4: These bytes are read-only and hold parameter values:
  - vendor ID at 0x00-0x01
  - device ID at 0x02-0x03
  - revision at 0x08
  - class code at 0x09-0x0b
  - header type at 0x0e

  Writes to them are ignored.
- R5: Base-address register n sits at offset 0x10+4n for n = 0..5, and the ROM base register sits at 0x30. Bit 0 of a base-address register reads 1 for an I/O region and 0 for a memory region. Bits below the region size are not writable, so writing all ones reads back the inverse of (size-1), with the type bit in place.
- R6: A region of size 0 always reads as zero and never decodes.
- R7: A region's base is its register value ANDed with the inverse of (size-1). The region hits exactly the addresses from base through base+size-1.
- R8: The command register is at offset 0x04. I/O regions decode only while its bit 0 is 1. Memory regions, including the ROM, decode only while its bit 1 is 1.
- R9: The ROM region also needs bit 0 of its base register to be 1. Apart from that bit, every ROM bit below the ROM size reads zero.
- R10: An I/O query (space select 1) hits only I/O regions. A memory query (space select 0) hits only memory regions.
- R11: After a write, reads reflect the new bytes from the next cycle on. Windows and hits change in the cycle after the write's clock edge, never in the cycle of the write.
- R12: Reset clears every writable byte to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access request present |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_off_i | input | 8 | Byte offset of the access |
| acc_len_i | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| acc_wdata_i | input | 32 | Write data, little-endian |
| acc_rdata_o | output | 32 | Read data; zero when no read is requested |
| q_addr_i | input | 32 | Address to match against the windows |
| q_io_i | input | 1 | Query space: 1 = I/O, 0 = memory |
| win_en_o | output | 7 | Window enables; bit 6 is the ROM |
| win_base_o | output | 224 | Window bases, 32 bits each; window r is on bits 32r+31..32r |
| hit_o | output | 7 | Per-window hit for the current query |

## Verification
A write to the command register or to a base register can occur in the same cycle as an address query that depends on it. The bench provokes this by driving the write and a matching query on the same falling edge. Before the rising edge it requires the hit vector that the old register state predicts. With the query held and the write removed, it then requires the hit vector of the new state. Random traffic adds further cases where writes land on the enables, the base registers and the ROM enable while queries run. Each query result is compared against a bench model updated only at write edges.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int NUM_BAR = 6;
  localparam int NUM_WIN = NUM_BAR + 1;
  localparam int ROM_IDX = NUM_BAR;
  localparam int BAR_OFF = 16;
  localparam int ROM_OFF = 48;
  localparam int CMD_OFF = 4;

  typedef logic [NUM_BAR-1:0][31:0] bar_sizes_t;
  typedef logic [NUM_BAR-1:0]       bar_io_t;
  typedef enum logic [1:0] {LEN_B = 2'd0, LEN_H = 2'd1, LEN_W = 2'd2, LEN_WX = 2'd3} acc_len_e;

  // Returns the window whose register holds byte idx, or -1 if none does
  function automatic int win_of(int idx);
    if (idx >= BAR_OFF && idx < BAR_OFF + 4*NUM_BAR) return (idx - BAR_OFF) / 4;
    if (idx >= ROM_OFF && idx < ROM_OFF + 4) return ROM_IDX;
    return -1;
  endfunction

  function automatic logic [31:0] win_wmask(int r, bar_sizes_t sizes, bar_io_t io,
                                            logic [31:0] rom);
    logic [31:0] s;
    if (r == ROM_IDX) return (rom == 32'h0) ? 32'h0 : (~(rom - 32'd1) | 32'h1);
    s = sizes[r];
    if (s == 32'h0) return 32'h0;
    return ~(s - 32'd1) & (io[r] ? 32'hffff_fffc : 32'hffff_fff0);
  endfunction

  function automatic logic [31:0] win_rst(int r, bar_sizes_t sizes, bar_io_t io);
    if (r == ROM_IDX) return 32'h0;
    return (sizes[r] != 32'h0 && io[r]) ? 32'h1 : 32'h0;
  endfunction

  function automatic logic [7:0] byte_wmask(int idx, bar_sizes_t sizes, bar_io_t io,
                                            logic [31:0] rom);
    logic [31:0] m;
    int w;
    w = win_of(idx);
    if (w >= 0) begin
      m = win_wmask(w, sizes, io, rom);
      return m[8*(idx%4) +: 8];
    end
    if (idx < 4 || (idx >= 8 && idx < 12) || idx == 14) return 8'h00;
    return 8'hff;
  endfunction

  function automatic logic [7:0] byte_rst(int idx, bar_sizes_t sizes, bar_io_t io,
                                          logic [15:0] vid, logic [15:0] did,
                                          logic [7:0] rev, logic [23:0] cls,
                                          logic [7:0] hdr);
    logic [31:0] v;
    int w;
    w = win_of(idx);
    if (w >= 0) begin
      v = win_rst(w, sizes, io);
      return v[8*(idx%4) +: 8];
    end
    case (idx)
      0:  return vid[7:0];
      1:  return vid[15:8];
      2:  return did[7:0];
      3:  return did[15:8];
      8:  return rev;
      9:  return cls[7:0];
      10: return cls[15:8];
      11: return cls[23:16];
      14: return hdr;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_space_pkg::*;
#(
  parameter int          DEPTH       = 256,
  parameter int          LANES       = 4,
  parameter bar_sizes_t  BAR_SIZE    = '0,
  parameter bar_io_t     BAR_IO      = '0,
  parameter logic [31:0] ROM_SIZE    = 32'h0,
  parameter logic [15:0] VENDOR_ID   = 16'h0,
  parameter logic [15:0] DEVICE_ID   = 16'h0,
  parameter logic [7:0]  REVISION    = 8'h0,
  parameter logic [23:0] CLASS_CODE  = 24'h0,
  parameter logic [7:0]  HEADER_TYPE = 8'h0,
  localparam int         AW          = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            lane_we_i,
  input  logic [LANES-1:0][AW-1:0]    lane_off_i,
  input  logic [8*LANES-1:0]          wdata_i,
  output logic [DEPTH-1:0][7:0]       bytes_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    localparam logic [7:0] WM = byte_wmask(i, BAR_SIZE, BAR_IO, ROM_SIZE);
    localparam logic [7:0] RV = byte_rst(i, BAR_SIZE, BAR_IO, VENDOR_ID, DEVICE_ID,
                                         REVISION, CLASS_CODE, HEADER_TYPE);
    if (WM == 8'h00) begin : g_const
      assign bytes_o[i] = RV;
    end else begin : g_reg
      logic       sel;
      logic [7:0] din;
      logic [7:0] q;
      always_comb begin
        sel = 1'b0;
        din = 8'h00;
        for (int k = 0; k < LANES; k++) begin
          if (lane_we_i[k] && lane_off_i[k] == AW'(i)) begin
            sel = 1'b1;
            din = wdata_i[8*k +: 8];
          end
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= RV;
        else if (sel) q <= (q & ~WM) | (din & WM);
      end
      assign bytes_o[i] = q;
    end
  end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_space_pkg::*;
#(
  parameter int  DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][7:0] bytes_i,
  input  logic [AW-1:0]         off_i,
  input  logic [1:0]            len_i,
  output logic [31:0]           rdata_o
);
  int req;
  int n;

  always_comb begin
    case (acc_len_e'(len_i))
      LEN_B:   req = 1;
      LEN_H:   req = 2;
      default: req = 4;
    endcase
    // Width degrades near the top of the space
    if (req == 4 && int'(off_i) <= DEPTH - 4)      n = 4;
    else if (req >= 2 && int'(off_i) <= DEPTH - 2) n = 2;
    else                                           n = 1;
    for (int k = 0; k < 4; k++)
      rdata_o[8*k +: 8] = (k < n) ? bytes_i[off_i + AW'(k)] : 8'h00;
  end
endmodule

// File: rtl/cfg_region.sv
module cfg_region #(
  parameter logic [31:0] SIZE   = 32'h0,
  parameter bit          IS_IO  = 1'b0,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic [31:0] raw_i,
  input  logic        io_en_i,
  input  logic        mem_en_i,
  input  logic [31:0] q_addr_i,
  input  logic        q_io_i,
  output logic        en_o,
  output logic [31:0] base_o,
  output logic        hit_o
);
  localparam logic [31:0] AMASK = (SIZE == 32'h0) ? 32'h0 : ~(SIZE - 32'd1);

  assign base_o = raw_i & AMASK;
  assign en_o   = (SIZE != 32'h0) && (IS_IO ? io_en_i : mem_en_i) && (!IS_ROM || raw_i[0]);
  assign hit_o  = en_o && (q_io_i == IS_IO) && ((q_addr_i & AMASK) == base_o);
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter bar_sizes_t  BAR_SIZE    = {32'h0, 32'h100, 32'h10_0000, 32'h0, 32'h1000, 32'h20},
  parameter bar_io_t     BAR_IO      = 6'b010001,
  parameter logic [31:0] ROM_SIZE    = 32'h1_0000,
  parameter logic [15:0] VENDOR_ID   = 16'h1af4,
  parameter logic [15:0] DEVICE_ID   = 16'h5a3c,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  HEADER_TYPE = 8'h00
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc_valid_i,
  input  logic                  acc_we_i,
  input  logic [7:0]            acc_off_i,
  input  logic [1:0]            acc_len_i,
  input  logic [31:0]           acc_wdata_i,
  output logic [31:0]           acc_rdata_o,
  input  logic [31:0]           q_addr_i,
  input  logic                  q_io_i,
  output logic [NUM_WIN-1:0]    win_en_o,
  output logic [NUM_WIN*32-1:0] win_base_o,
  output logic [NUM_WIN-1:0]    hit_o
);
  localparam int DEPTH = 256;
  localparam int LANES = 4;
  localparam int AW    = $clog2(DEPTH);

  logic [DEPTH-1:0][7:0]    cfg_bytes;
  logic [LANES-1:0]         lane_we;
  logic [LANES-1:0][AW-1:0] lane_off;
  logic [31:0]              rd_word;
  logic                     io_en;
  logic                     mem_en;
  int                       nbytes;

  always_comb begin
    logic [AW:0] pos;
    case (acc_len_e'(acc_len_i))
      LEN_B:   nbytes = 1;
      LEN_H:   nbytes = 2;
      default: nbytes = 4;
    endcase
    for (int k = 0; k < LANES; k++) begin
      pos         = {1'b0, acc_off_i} + (AW+1)'(k);
      // Lanes past the last byte are dropped, never wrapped
      lane_we[k]  = acc_valid_i && acc_we_i && (k < nbytes) && !pos[AW];
      lane_off[k] = pos[AW-1:0];
    end
  end

  cfg_store #(
    .DEPTH(DEPTH), .LANES(LANES), .BAR_SIZE(BAR_SIZE), .BAR_IO(BAR_IO),
    .ROM_SIZE(ROM_SIZE), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION(REVISION), .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_we_i  (lane_we),
    .lane_off_i (lane_off),
    .wdata_i    (acc_wdata_i),
    .bytes_o    (cfg_bytes)
  );

  cfg_rd_mux #(.DEPTH(DEPTH)) u_rd (
    .bytes_i (cfg_bytes),
    .off_i   (acc_off_i),
    .len_i   (acc_len_i),
    .rdata_o (rd_word)
  );

  assign acc_rdata_o = (acc_valid_i && !acc_we_i) ? rd_word : 32'h0;
  assign io_en       = cfg_bytes[CMD_OFF][0];
  assign mem_en      = cfg_bytes[CMD_OFF][1];

  for (genvar r = 0; r < NUM_WIN; r++) begin : g_win
    localparam int          OFF = (r < NUM_BAR) ? BAR_OFF + 4*r : ROM_OFF;
    localparam logic [31:0] SZ  = (r < NUM_BAR) ? BAR_SIZE[r % NUM_BAR] : ROM_SIZE;
    localparam bit          IO  = (r < NUM_BAR) ? BAR_IO[r % NUM_BAR] : 1'b0;
    logic [31:0] raw;
    assign raw = {cfg_bytes[OFF+3], cfg_bytes[OFF+2], cfg_bytes[OFF+1], cfg_bytes[OFF]};
    cfg_region #(.SIZE(SZ), .IS_IO(IO), .IS_ROM(r == ROM_IDX)) u_reg (
      .raw_i    (raw),
      .io_en_i  (io_en),
      .mem_en_i (mem_en),
      .q_addr_i (q_addr_i),
      .q_io_i   (q_io_i),
      .en_o     (win_en_o[r]),
      .base_o   (win_base_o[32*r +: 32]),
      .hit_o    (hit_o[r])
    );
  end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk
  import cfg_space_pkg::*;
#(
  parameter bar_sizes_t  BAR_SIZE  = '0,
  parameter bar_io_t     BAR_IO    = '0,
  parameter logic [31:0] ROM_SIZE  = 32'h0,
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_valid_i,
  input logic               acc_we_i,
  input logic [7:0]         acc_off_i,
  input logic [31:0]        acc_rdata_o,
  input logic [NUM_WIN-1:0] win_en_o,
  input logic [NUM_WIN-1:0] hit_o,
  input logic [1:0]         cmd_i,
  input logic               rom_bit_i,
  input logic [31:0]        ids_i
);
  localparam logic [NUM_WIN-1:0] IO_WINS  = {1'b0, BAR_IO};
  localparam logic [NUM_WIN-1:0] MEM_WINS = ~IO_WINS;

  function automatic logic [NUM_WIN-1:0] zero_wins();
    logic [NUM_WIN-1:0] z;
    for (int r = 0; r < NUM_BAR; r++) z[r] = (BAR_SIZE[r] == 32'h0);
    z[ROM_IDX] = (ROM_SIZE == 32'h0);
    return z;
  endfunction
  localparam logic [NUM_WIN-1:0] ZERO_WINS = zero_wins();

  // R7
  hit_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & ~win_en_o) == '0);
  // R8
  io_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i[0] |-> (win_en_o & IO_WINS) == '0);
  // R8
  mem_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i[1] |-> (win_en_o & MEM_WINS) == '0);
  // R9
  rom_needs_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_bit_i |-> !win_en_o[ROM_IDX]);
  // R6
  zero_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_en_o & ZERO_WINS) == '0);
  // R4
  ids_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ids_i == {DEVICE_ID, VENDOR_ID});
  // R1
  top_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_we_i && acc_off_i == 8'hff) |-> acc_rdata_o[31:8] == 24'h0);
  // R11
  win_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_en_o & ~$past(win_en_o)) != '0 |-> $past(acc_valid_i && acc_we_i));
endmodule

bind cfg_space cfg_space_chk #(
  .BAR_SIZE(BAR_SIZE), .BAR_IO(BAR_IO), .ROM_SIZE(ROM_SIZE),
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_we_i    (acc_we_i),
  .acc_off_i   (acc_off_i),
  .acc_rdata_o (acc_rdata_o),
  .win_en_o    (win_en_o),
  .hit_o       (hit_o),
  .cmd_i       (cfg_bytes[4][1:0]),
  .rom_bit_i   (cfg_bytes[48][0]),
  .ids_i       ({cfg_bytes[3], cfg_bytes[2], cfg_bytes[1], cfg_bytes[0]})
);

// File: tb/sim_cfg_space.sv
module sim_cfg_space;
  localparam int PERIOD = 10;
  localparam logic [5:0][31:0] BSZ = {32'h0, 32'h100, 32'h10_0000, 32'h0, 32'h1000, 32'h20};
  localparam logic [5:0]       BIO = 6'b010001;
  localparam logic [31:0]      RSZ = 32'h1_0000;
  localparam logic [15:0]      VID = 16'h1af4;
  localparam logic [15:0]      DID = 16'h5a3c;
  localparam logic [7:0]       REV = 8'h03;
  localparam logic [23:0]      CLS = 24'h020000;
  localparam logic [7:0]       HDR = 8'h00;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0, acc_we = 1'b0;
  logic [7:0]   acc_off = 8'h0;
  logic [1:0]   acc_len = 2'd0;
  logic [31:0]  acc_wdata = 32'h0;
  logic [31:0]  acc_rdata;
  logic [31:0]  q_addr = 32'h0;
  logic         q_io = 1'b0;
  logic [6:0]   win_en, hit;
  logic [223:0] win_base;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;
  logic [7:0] ref_mem [256];

  always #(PERIOD/2) clk = ~clk;

  cfg_space #(.BAR_SIZE(BSZ), .BAR_IO(BIO), .ROM_SIZE(RSZ), .VENDOR_ID(VID),
              .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS), .HEADER_TYPE(HDR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_we_i(acc_we),
    .acc_off_i(acc_off), .acc_len_i(acc_len), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .q_addr_i(q_addr), .q_io_i(q_io),
    .win_en_o(win_en), .win_base_o(win_base), .hit_o(hit));

  function automatic longint size_of(int r);
    return (r < 6) ? longint'(BSZ[r]) : longint'(RSZ);
  endfunction
  function automatic bit io_of(int r);
    return (r < 6) ? BIO[r] : 1'b0;
  endfunction

  // R5 R9: writable bits of region registers; R4 read-only id bytes
  function automatic logic [7:0] ref_wmask(int a);
    logic [31:0] m;
    longint sz;
    int r;
    if ((a >= 16 && a < 40) || (a >= 48 && a < 52)) begin
      r  = (a >= 48) ? 6 : (a - 16) / 4;
      sz = size_of(r);
      if (sz == 0) m = 32'h0;
      else if (r == 6) m = ~32'(sz - 1) | 32'h1;
      else m = ~32'(sz - 1) & (io_of(r) ? 32'hffff_fffc : 32'hffff_fff0);
      return m[8*(a%4) +: 8];
    end
    if (a <= 3 || (a >= 8 && a <= 11) || a == 14) return 8'h00;
    return 8'hff;
  endfunction

  function automatic void ref_reset();
    for (int a = 0; a < 256; a++) ref_mem[a] = 8'h00;
    {ref_mem[3], ref_mem[2], ref_mem[1], ref_mem[0]} = {DID, VID};
    ref_mem[8] = REV;
    {ref_mem[11], ref_mem[10], ref_mem[9]} = CLS;
    ref_mem[14] = HDR;
    for (int r = 0; r < 6; r++) if (BSZ[r] != 0 && BIO[r]) ref_mem[16 + 4*r] = 8'h01;
  endfunction

  function automatic int len_bytes(logic [1:0] l);
    return (l == 2'd0) ? 1 : (l == 2'd1) ? 2 : 4;
  endfunction

  function automatic void ref_write(int off, logic [1:0] l, logic [31:0] d);
    logic [7:0] m;
    for (int k = 0; k < len_bytes(l); k++) begin
      if (off + k > 255) break;
      m = ref_wmask(off + k);
      ref_mem[off + k] = (ref_mem[off + k] & ~m) | (d[8*k +: 8] & m);
    end
  endfunction

  function automatic logic [31:0] exp_read(int off, logic [1:0] l);
    int n;
    logic [31:0] v;
    n = len_bytes(l);
    if (!(n == 4 && off <= 252)) n = (n >= 2 && off <= 254) ? 2 : 1;
    v = 32'h0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = ref_mem[off + k];
    return v;
  endfunction

  function automatic logic [31:0] ref_reg(int r);
    int o;
    o = (r < 6) ? 16 + 4*r : 48;
    return {ref_mem[o+3], ref_mem[o+2], ref_mem[o+1], ref_mem[o]};
  endfunction

  function automatic logic [31:0] exp_base(int r);
    longint sz;
    sz = size_of(r);
    return (sz == 0) ? 32'h0 : ref_reg(r) & ~32'(sz - 1);
  endfunction

  function automatic bit exp_en(int r);
    bit e;
    if (size_of(r) == 0) return 1'b0;
    e = io_of(r) ? ref_mem[4][0] : ref_mem[4][1];
    if (r == 6) e = e && ref_reg(6)[0];
    return e;
  endfunction

  function automatic logic [6:0] exp_hits(logic [31:0] a, logic io);
    logic [6:0] h;
    longint b;
    for (int r = 0; r < 7; r++) begin
      b = longint'(exp_base(r));
      h[r] = exp_en(r) && (io == io_of(r)) && longint'(a) >= b && longint'(a) <= b + size_of(r) - 1;
    end
    return h;
  endfunction

  function automatic logic [223:0] exp_bases();
    logic [223:0] v;
    for (int r = 0; r < 7; r++) v[32*r +: 32] = exp_base(r);
    return v;
  endfunction

  function automatic logic [6:0] exp_ens();
    logic [6:0] v;
    for (int r = 0; r < 7; r++) v[r] = exp_en(r);
    return v;
  endfunction

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int off, logic [1:0] l, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; acc_off = 8'(off); acc_len = l; acc_wdata = d;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; acc_we = 1'b0;
    ref_write(off, l, d);
  endtask

  task automatic rd(int off, logic [1:0] l, string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b0; acc_off = 8'(off); acc_len = l;
    #1;
    chk(tag, 256'(acc_rdata), 256'(exp_read(off, l)));
    acc_valid = 1'b0;
  endtask

  task automatic qry(logic [31:0] a, logic io, string tag);
    @(negedge clk);
    q_addr = a; q_io = io;
    #1;
    chk(tag, 256'(hit), 256'(exp_hits(a, io)));
  endtask

  task automatic chk_windows(string tag);
    @(negedge clk);
    #1;
    chk({tag, " en"}, 256'(win_en), 256'(exp_ens()));
    chk({tag, " base"}, 256'(win_base), 256'(exp_bases()));
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [1:0]  l;
    int          off, r;
    void'($urandom(32'd7741));
    ref_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    rd(0, 2'd2, "R4 reset ids");
    rd(16, 2'd2, "R5 reset bar0 type");
    rd(4, 2'd2, "R12 reset cmd");
    rd(8, 2'd2, "R4 rev/class");
    chk_windows("R12 reset windows");

    // Sizing with all ones
    for (int i = 0; i < 6; i++) wr(16 + 4*i, 2'd2, 32'hffff_ffff);
    wr(48, 2'd2, 32'hffff_fffe);
    for (int i = 0; i < 6; i++) rd(16 + 4*i, 2'd2, "R5 R6 bar sizing");
    rd(48, 2'd3, "R9 rom sizing");

    // Read-only ids ignore writes
    wr(0, 2'd2, 32'h0);
    wr(8, 2'd2, 32'hdead_beef);
    wr(14, 2'd0, 8'h7f);
    rd(0, 2'd2, "R4 id after write");
    rd(8, 2'd2, "R4 class after write");
    rd(14, 2'd0, "R4 header after write");

    // Width degrade and little-endian at the top
    wr(252, 2'd2, 32'h4433_2211);
    rd(252, 2'd2, "R2 le word");
    rd(253, 2'd2, "R1 degrade at fd");
    rd(254, 2'd3, "R1 degrade at fe");
    rd(255, 2'd2, "R1 degrade at ff");
    rd(255, 2'd1, "R1 half at ff");
    rd(253, 2'd1, "R2 half at fd");
    wr(254, 2'd2, 32'haabb_ccdd);
    rd(252, 2'd2, "R3 write stops at ff");
    rd(0, 2'd2, "R3 no wrap to 00");
    wr(64, 2'd1, 32'h1234_5678);
    rd(64, 2'd2, "R3 half write only two bytes");

    // Program windows with decoding disabled
    wr(16, 2'd2, 32'h0000_1000);
    wr(20, 2'd2, 32'h8000_0000);
    wr(28, 2'd2, 32'h4010_0000);
    wr(32, 2'd2, 32'h0000_2000);
    wr(48, 2'd2, 32'h000d_0000);
    wr(4, 2'd1, 16'h0000);
    qry(32'h1004, 1'b1, "R8 io off");
    qry(32'h8000_0010, 1'b0, "R8 mem off");
    chk_windows("R7 programmed");

    // Command write and query in the same cycle
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; acc_off = 8'd4; acc_len = 2'd0; acc_wdata = 32'h1;
    q_addr = 32'h1004; q_io = 1'b1;
    #1 chk("R11 same cycle old hit", 256'(hit), 256'(exp_hits(32'h1004, 1'b1)));
    @(posedge clk);
    #1 acc_valid = 1'b0; acc_we = 1'b0;
    ref_write(4, 2'd0, 32'h1);
    @(negedge clk);
    #1 chk("R11 next cycle new hit", 256'(hit), 256'(exp_hits(32'h1004, 1'b1)));
    chk("R11 bar0 hit set", 256'(hit[0]), 256'(1'b1));

    // Boundaries and space selection
    wr(4, 2'd0, 32'h3);
    qry(32'h1000, 1'b1, "R7 io first");
    qry(32'h101f, 1'b1, "R7 io last");
    qry(32'h1020, 1'b1, "R7 io past end");
    qry(32'h0fff, 1'b1, "R7 io before base");
    qry(32'h1000, 1'b0, "R10 mem query at io base");
    qry(32'h8000_0fff, 1'b0, "R7 mem last");
    qry(32'h8000_0fff, 1'b1, "R10 io query at mem");
    qry(32'h000d_0100, 1'b0, "R9 rom without enable");
    wr(48, 2'd0, 32'h1);
    qry(32'h000d_0100, 1'b0, "R9 rom enabled");
    qry(32'h000e_0000, 1'b0, "R9 rom past end");
    wr(4, 2'd0, 32'h1);
    qry(32'h000d_0100, 1'b0, "R8 rom needs mem enable");
    qry(32'h2080, 1'b1, "R8 io stays on");
    chk_windows("R8 windows io only");
    wr(4, 2'd0, 32'h3);

    // Random traffic
    for (int it = 0; it < 400; it++) begin
      off = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 64);
      l   = 2'($urandom);
      if ($urandom % 3 == 0) wr(4, 2'd0, 32'h3);
      else wr(off, l, $urandom);
      rd(int'($urandom % 256), 2'($urandom), "R1 R2 random read");
      r = int'($urandom % 7);
      if (size_of(r) != 0 && $urandom % 4 != 0)
        a = exp_base(r) + 32'($urandom % 32'(size_of(r)));
      else
        a = $urandom;
      qry(a, ($urandom % 4 == 0) ? ~io_of(r) : io_of(r), "R7 R10 random query");
      if (it % 20 == 0) chk_windows("R7 random windows");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule